// File: doc/BRIEF.md
# Protected Execution Mode Controller

This block tracks a protected execution mode inside a processor core. It holds the mode status, the address at which an interrupted protected thread must resume, and a 128-bit digest of that thread's saved register state. Decoded strobes from the pipeline tell it when the protected mode is entered or left, when an interrupt arrives, and when a return instruction executes. An external crypto engine does the cipher and hash work. The controller raises one request at a time towards that engine and waits for the engine's acknowledge, which carries the resulting digest.

Only one thread may own the protected mode at a time. When an interrupt hits the protected thread, the controller asks the engine to encrypt the whole register file as one unit. It then stores the ciphertext digest on chip and hands control to the interrupt handler with the mode marked as held but not active. A later return goes back into the protected mode only if two conditions hold: the target equals the saved address, and the digest of the decrypted registers equals the stored one. A clean exit clears the status and the saved address, and it asks for the general-purpose registers to be wiped.

Top module: `shield_mode_ctrl`

## Requirements
- R1: After reset `status_o` is 2'b00 and `saved_pc_o` is 0. The outputs `enc_req_o`, `dec_req_o`, `busy_o`, `rf_clear_o`, `handoff_o`, `resume_o`, `exc_reentry_o` and `exc_integrity_o` are all 0.
- R2: Status encoding: bit 0 means the current instruction stream runs in protected mode, and bit 1 means some thread holds the mode. When `enter_i` arrives with status 2'b00, the status becomes 2'b11 one cycle later.
- R3: When `enter_i` arrives while either status bit is set, `exc_reentry_o` pulses high for one cycle in the next cycle and the status does not change.
- R4: `leave_i` is honoured while no thread holds the mode or while the protected stream runs (status 2'b00 or 2'b11, no request outstanding). One cycle later it gives a one-cycle `rf_clear_o` pulse, status 2'b00 and `saved_pc_o` = 0.
- R5: `irq_i` at status 2'b11 captures `irq_pc_i` into `saved_pc_o` and raises `enc_req_o` in the next cycle.
- R6: An `eng_ack_i` during an encrypt request stores `eng_digest_i` as the reference digest. One cycle later the status becomes 2'b10, `enc_req_o` drops and `handoff_o` pulses for one cycle.
- R7: At status 2'b10, `ret_i` with `ret_pc_i` equal to `saved_pc_o` raises `dec_req_o` in the next cycle. Any other target raises no request.
- R8: An `eng_ack_i` during a decrypt request whose `eng_digest_i` equals the reference digest sets the status to 2'b11 and pulses `resume_o` one cycle later.
- R9: An `eng_ack_i` during a decrypt request whose digest differs from the reference pulses `exc_integrity_o`. The status stays 2'b10 and `saved_pc_o` is kept, so a later matching return can try again.
- R10: `ret_i` is ignored while status bit 1 is 0, even when `ret_pc_i` equals `saved_pc_o`.
- R11: At most one of `enc_req_o` and `dec_req_o` is high. A request stays high until `eng_ack_i`, and `busy_o` is high exactly while one is outstanding. While busy, `irq_i`, `ret_i` and `leave_i` have no effect on the requests, the status or `saved_pc_o`.
- R12: `irq_i` while status bit 0 is 0 raises no request and leaves `saved_pc_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_i | input | 1 | Begin-protected-mode strobe |
| leave_i | input | 1 | End-protected-mode strobe |
| irq_i | input | 1 | Interrupt entry event |
| irq_pc_i | input | 64 | Address at which the interrupted stream resumes |
| ret_i | input | 1 | Return instruction executed |
| ret_pc_i | input | 64 | Return target address |
| eng_ack_i | input | 1 | Crypto engine finished the current request |
| eng_digest_i | input | 128 | Digest delivered with the acknowledge |
| status_o | output | 2 | Mode status: bit 0 active, bit 1 held |
| saved_pc_o | output | 64 | Saved resume address |
| enc_req_o | output | 1 | Register-file encrypt-and-hash request |
| dec_req_o | output | 1 | Register-file decrypt-and-hash request |
| busy_o | output | 1 | A crypto request is outstanding |
| rf_clear_o | output | 1 | Wipe general-purpose registers (pulse) |
| handoff_o | output | 1 | Save done, control to interrupt handler (pulse) |
| resume_o | output | 1 | Protected mode resumed after restore (pulse) |
| exc_reentry_o | output | 1 | Begin requested while mode is held (pulse) |
| exc_integrity_o | output | 1 | Restore digest mismatch (pulse) |

## Verification
The hardest situation to reach is a failed restore followed by a successful retry. Getting there takes the full chain: enter, interrupt, a held encrypt request, an acknowledge, a non-matching return, and then a matching return whose acknowledge carries a corrupted digest. The bench sweeps a set of addresses and digests computed from the loop index. On every odd pass it feeds the flipped digest first and checks that the saved address survives, then retries with the true digest. While each request is held without an acknowledge, it also drives stray interrupts, returns and exits to show they change nothing.

// File: rtl/shm_pkg.sv
package shm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_SAVE    = 3'd2,
    ST_OUT     = 3'd3,
    ST_RESTORE = 3'd4
  } shm_state_e;

  localparam int unsigned BIT_ACTIVE = 0;
  localparam int unsigned BIT_HELD   = 1;

  typedef struct packed {
    logic reentry;
    logic integrity;
    logic rf_clear;
    logic handoff;
    logic resume;
  } shm_pulse_t;
endpackage

// File: rtl/shm_status.sv
module shm_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_all,
  input  logic       set_full,
  input  logic       set_held,
  output logic [1:0] status_q
);
  import shm_pkg::*;

  logic [1:0] status_d;
  logic       status_en;

  always_comb begin
    status_d  = status_q;
    status_en = clr_all | set_full | set_held;
    if (clr_all) begin
      status_d = 2'b00;
    end else if (set_full) begin
      status_d[BIT_ACTIVE] = 1'b1;
      status_d[BIT_HELD]   = 1'b1;
    end else if (set_held) begin
      status_d[BIT_ACTIVE] = 1'b0;
      status_d[BIT_HELD]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 2'b00;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/shm_vault.sv
module shm_vault #(
  parameter int unsigned AW      = 64,
  parameter int unsigned HW      = 128,
  parameter int unsigned SLICE_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_pc,
  input  logic          clr_pc,
  input  logic [AW-1:0] pc_in,
  input  logic          cap_dig,
  input  logic          clr_dig,
  input  logic [HW-1:0] dig_in,
  input  logic [AW-1:0] ret_pc,
  output logic [AW-1:0] pc_q,
  output logic          pc_match,
  output logic          dig_match
);
  localparam int unsigned SLICES = HW / SLICE_W;

  logic [HW-1:0]     dig_q;
  logic [AW-1:0]     pc_d;
  logic [HW-1:0]     dig_d;
  logic              pc_en;
  logic              dig_en;
  logic [SLICES-1:0] slice_eq;

  always_comb begin
    pc_en  = cap_pc | clr_pc;
    pc_d   = clr_pc ? '0 : pc_in;
    dig_en = cap_dig | clr_dig;
    dig_d  = clr_dig ? '0 : dig_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q <= '0;
    end else if (dig_en) begin
      dig_q <= dig_d;
    end
  end

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    assign slice_eq[g] = (dig_in[g*SLICE_W +: SLICE_W] == dig_q[g*SLICE_W +: SLICE_W]);
  end

  assign dig_match = &slice_eq;
  assign pc_match  = (ret_pc == pc_q);
endmodule

// File: rtl/shm_seq.sv
module shm_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_i,
  input  logic       leave_i,
  input  logic       irq_i,
  input  logic       ret_i,
  input  logic       ack_i,
  input  logic [1:0] status_i,
  input  logic       pc_match_i,
  input  logic       dig_match_i,
  output logic       clr_all_o,
  output logic       set_full_o,
  output logic       set_held_o,
  output logic       cap_pc_o,
  output logic       cap_dig_o,
  output logic       enc_req_o,
  output logic       dec_req_o,
  output shm_pkg::shm_pulse_t pulse_o
);
  import shm_pkg::*;

  shm_state_e st_q, st_d;
  shm_pulse_t pulse_d;
  logic       held;

  assign held = status_i[BIT_HELD];

  always_comb begin
    st_d       = st_q;
    clr_all_o  = 1'b0;
    set_full_o = 1'b0;
    set_held_o = 1'b0;
    cap_pc_o   = 1'b0;
    cap_dig_o  = 1'b0;
    pulse_d    = '0;
    pulse_d.reentry = enter_i && (status_i != 2'b00);
    unique case (st_q)
      ST_IDLE: begin
        if (enter_i && (status_i == 2'b00)) begin
          set_full_o = 1'b1;
          st_d       = ST_RUN;
        end else if (leave_i) begin
          clr_all_o        = 1'b1;
          pulse_d.rf_clear = 1'b1;
        end
      end
      ST_RUN: begin
        if (leave_i) begin
          clr_all_o        = 1'b1;
          pulse_d.rf_clear = 1'b1;
          st_d             = ST_IDLE;
        end else if (irq_i) begin
          cap_pc_o = 1'b1;
          st_d     = ST_SAVE;
        end
      end
      ST_SAVE: begin
        if (ack_i) begin
          cap_dig_o       = 1'b1;
          set_held_o      = 1'b1;
          pulse_d.handoff = 1'b1;
          st_d            = ST_OUT;
        end
      end
      ST_OUT: begin
        if (ret_i && held && pc_match_i) begin
          st_d = ST_RESTORE;
        end
      end
      ST_RESTORE: begin
        if (ack_i) begin
          if (dig_match_i) begin
            set_full_o     = 1'b1;
            pulse_d.resume = 1'b1;
            st_d           = ST_RUN;
          end else begin
            pulse_d.integrity = 1'b1;
            st_d              = ST_OUT;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pulse_o <= '0;
    end else begin
      st_q    <= st_d;
      pulse_o <= pulse_d;
    end
  end

  assign enc_req_o = (st_q == ST_SAVE);
  assign dec_req_o = (st_q == ST_RESTORE);
endmodule

// File: rtl/shield_mode_ctrl.sv
module shield_mode_ctrl #(
  parameter int unsigned AW      = 64,
  parameter int unsigned HW      = 128,
  parameter int unsigned SLICE_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter_i,
  input  logic          leave_i,
  input  logic          irq_i,
  input  logic [AW-1:0] irq_pc_i,
  input  logic          ret_i,
  input  logic [AW-1:0] ret_pc_i,
  input  logic          eng_ack_i,
  input  logic [HW-1:0] eng_digest_i,
  output logic [1:0]    status_o,
  output logic [AW-1:0] saved_pc_o,
  output logic          enc_req_o,
  output logic          dec_req_o,
  output logic          busy_o,
  output logic          rf_clear_o,
  output logic          handoff_o,
  output logic          resume_o,
  output logic          exc_reentry_o,
  output logic          exc_integrity_o
);
  import shm_pkg::*;

  logic       clr_all, set_full, set_held, cap_pc, cap_dig;
  logic       pc_match, dig_match;
  logic [1:0] status_q;
  shm_pulse_t pulse;

  shm_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_i     (enter_i),
    .leave_i     (leave_i),
    .irq_i       (irq_i),
    .ret_i       (ret_i),
    .ack_i       (eng_ack_i),
    .status_i    (status_q),
    .pc_match_i  (pc_match),
    .dig_match_i (dig_match),
    .clr_all_o   (clr_all),
    .set_full_o  (set_full),
    .set_held_o  (set_held),
    .cap_pc_o    (cap_pc),
    .cap_dig_o   (cap_dig),
    .enc_req_o   (enc_req_o),
    .dec_req_o   (dec_req_o),
    .pulse_o     (pulse)
  );

  shm_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (clr_all),
    .set_full (set_full),
    .set_held (set_held),
    .status_q (status_q)
  );

  shm_vault #(.AW(AW), .HW(HW), .SLICE_W(SLICE_W)) u_vault (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_pc    (cap_pc),
    .clr_pc    (clr_all),
    .pc_in     (irq_pc_i),
    .cap_dig   (cap_dig),
    .clr_dig   (clr_all),
    .dig_in    (eng_digest_i),
    .ret_pc    (ret_pc_i),
    .pc_q      (saved_pc_o),
    .pc_match  (pc_match),
    .dig_match (dig_match)
  );

  assign status_o        = status_q;
  assign busy_o          = enc_req_o | dec_req_o;
  assign rf_clear_o      = pulse.rf_clear;
  assign handoff_o       = pulse.handoff;
  assign resume_o        = pulse.resume;
  assign exc_reentry_o   = pulse.reentry;
  assign exc_integrity_o = pulse.integrity;
endmodule

// File: rtl/shm_checker.sv
module shm_checker #(
  parameter int unsigned AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enter_i,
  input logic          irq_i,
  input logic          eng_ack_i,
  input logic [1:0]    status_o,
  input logic [AW-1:0] saved_pc_o,
  input logic          enc_req_o,
  input logic          dec_req_o,
  input logic          busy_o,
  input logic          rf_clear_o,
  input logic          resume_o,
  input logic          exc_reentry_o,
  input logic          exc_integrity_o
);
  assert_req_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enc_req_o, dec_req_o}));

  assert_enc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_req_o && !eng_ack_i) |=> enc_req_o);

  assert_dec_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req_o && !eng_ack_i) |=> dec_req_o);

  assert_status_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_o[0] && !status_o[1]));

  assert_reentry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_i && (status_o != 2'b00)) |=> (exc_reentry_o && $stable(status_o)));

  assert_clear_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_clear_o |-> (status_o == 2'b00 && saved_pc_o == '0));

  assert_resume_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> (status_o == 2'b11));

  assert_integrity_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_integrity_o |-> (status_o == 2'b10));

  assert_irq_outside_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && !status_o[0] && !busy_o) |=> (!enc_req_o && $stable(saved_pc_o)));
endmodule

bind shield_mode_ctrl shm_checker #(.AW(AW)) u_shm_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .enter_i         (enter_i),
  .irq_i           (irq_i),
  .eng_ack_i       (eng_ack_i),
  .status_o        (status_o),
  .saved_pc_o      (saved_pc_o),
  .enc_req_o       (enc_req_o),
  .dec_req_o       (dec_req_o),
  .busy_o          (busy_o),
  .rf_clear_o      (rf_clear_o),
  .resume_o        (resume_o),
  .exc_reentry_o   (exc_reentry_o),
  .exc_integrity_o (exc_integrity_o)
);

// File: tb/tb_shield_mode_ctrl.sv
`timescale 1ns/1ps
module tb_shield_mode_ctrl;
  localparam int AW = 64;
  localparam int HW = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enter_i, leave_i, irq_i, ret_i, eng_ack_i;
  logic [AW-1:0] irq_pc_i, ret_pc_i;
  logic [HW-1:0] eng_digest_i;
  logic [1:0]    status_o;
  logic [AW-1:0] saved_pc_o;
  logic          enc_req_o, dec_req_o, busy_o, rf_clear_o, handoff_o, resume_o;
  logic          exc_reentry_o, exc_integrity_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  always #4 clk = ~clk;

  shield_mode_ctrl #(.AW(AW), .HW(HW)) dut (
    .clk(clk), .rst_n(rst_n), .enter_i(enter_i), .leave_i(leave_i),
    .irq_i(irq_i), .irq_pc_i(irq_pc_i), .ret_i(ret_i), .ret_pc_i(ret_pc_i),
    .eng_ack_i(eng_ack_i), .eng_digest_i(eng_digest_i),
    .status_o(status_o), .saved_pc_o(saved_pc_o), .enc_req_o(enc_req_o),
    .dec_req_o(dec_req_o), .busy_o(busy_o), .rf_clear_o(rf_clear_o),
    .handoff_o(handoff_o), .resume_o(resume_o), .exc_reentry_o(exc_reentry_o),
    .exc_integrity_o(exc_integrity_o)
  );

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic clear_in();
    enter_i = 0; leave_i = 0; irq_i = 0; ret_i = 0; eng_ack_i = 0;
  endtask

  // Drive one cycle of stimulus; return 1 ns after the capturing edge.
  task automatic fire(input bit en, input bit lv, input bit iq, input logic [AW-1:0] ipc,
                      input bit rt, input logic [AW-1:0] rpc, input bit ak,
                      input logic [HW-1:0] dg);
    @(negedge clk);
    enter_i = en; leave_i = lv; irq_i = iq; irq_pc_i = ipc;
    ret_i = rt; ret_pc_i = rpc; eng_ack_i = ak; eng_digest_i = dg;
    @(posedge clk);
    #1;
    clear_in();
  endtask

  task automatic idle_cyc();
    fire(0, 0, 0, '0, 0, '0, 0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    clear_in();
    irq_pc_i = '0; ret_pc_i = '0; eng_digest_i = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk_eq("R1 status", status_o, 0);
    chk_eq("R1 saved_pc", saved_pc_o, 0);
    chk_eq("R1 outputs", {rf_clear_o, handoff_o, resume_o, exc_reentry_o,
                          exc_integrity_o, enc_req_o, dec_req_o, busy_o}, 0);
    @(negedge clk);
    rst_n = 1;

    // R10 return to address 0 with nothing held; R12 interrupt outside mode
    fire(0, 0, 0, '0, 1, '0, 0, '0);
    chk_eq("R10 ret ignored idle", {dec_req_o, busy_o, status_o}, 0);
    fire(0, 0, 1, 64'hDEAD, 0, '0, 0, '0);
    chk_eq("R12 irq idle no req", enc_req_o, 0);
    chk_eq("R12 irq idle pc kept", saved_pc_o, 0);

    // R4 exit while idle still wipes
    fire(0, 1, 0, '0, 0, '0, 0, '0);
    chk_eq("R4 idle exit clear", {rf_clear_o, status_o}, 3'b100);

    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] pc;
      logic [HW-1:0] dg;
      pc = 64'h4000_0000_0000_0000 + 64'(i) * 64'h0001_0203_0405_0607;
      dg = {4{32'h5A5A_0000 + 32'(i * 17)}};

      // R2 enter
      fire(1, 0, 0, '0, 0, '0, 0, '0);
      chk_eq("R2 enter status", status_o, 2'b11);
      chk_eq("R3 no false reentry", exc_reentry_o, 0);
      // R3 enter again
      fire(1, 0, 0, '0, 0, '0, 0, '0);
      chk_eq("R3 reentry pulse", exc_reentry_o, 1);
      chk_eq("R3 status kept", status_o, 2'b11);
      idle_cyc();
      chk_eq("R3 pulse one cycle", exc_reentry_o, 0);

      // R5 interrupt in mode
      fire(0, 0, 1, pc, 0, '0, 0, '0);
      chk_eq("R5 enc req", {enc_req_o, dec_req_o, busy_o}, 3'b101);
      chk_eq("R5 pc captured", saved_pc_o, pc);
      // R11 stray events while busy
      fire(0, 0, 1, ~pc, 0, '0, 0, '0);
      fire(0, 0, 0, '0, 1, pc, 0, '0);
      fire(0, 1, 0, '0, 0, '0, 0, '0);
      chk_eq("R11 enc held", {enc_req_o, dec_req_o, busy_o}, 3'b101);
      chk_eq("R11 pc unchanged", saved_pc_o, pc);
      chk_eq("R11 status unchanged", {rf_clear_o, status_o}, 3'b011);

      // R6 save acknowledge
      fire(0, 0, 0, '0, 0, '0, 1, dg);
      chk_eq("R6 status held", status_o, 2'b10);
      chk_eq("R6 handoff", {handoff_o, enc_req_o, busy_o}, 3'b100);
      // R3 enter while held but inactive
      fire(1, 0, 0, '0, 0, '0, 0, '0);
      chk_eq("R3 reentry held", {exc_reentry_o, status_o}, 3'b110);
      // R12 irq in handler
      fire(0, 0, 1, ~pc, 0, '0, 0, '0);
      chk_eq("R12 irq outside no req", enc_req_o, 0);
      chk_eq("R12 pc kept", saved_pc_o, pc);
      // R7 wrong target
      fire(0, 0, 0, '0, 1, pc ^ 64'h4, 0, '0);
      chk_eq("R7 mismatch no req", {dec_req_o, busy_o}, 0);

      if (i % 2 == 1) begin
        fire(0, 0, 0, '0, 1, pc, 0, '0);
        chk_eq("R7 dec req", {dec_req_o, busy_o}, 2'b11);
        fire(0, 0, 0, '0, 0, '0, 1, dg ^ (128'h1 << i));
        chk_eq("R9 integrity pulse", {exc_integrity_o, resume_o}, 2'b10);
        chk_eq("R9 status", status_o, 2'b10);
        chk_eq("R9 pc kept", saved_pc_o, pc);
        chk_eq("R9 no req", busy_o, 0);
      end

      fire(0, 0, 0, '0, 1, pc, 0, '0);
      chk_eq("R7 dec req", {enc_req_o, dec_req_o, busy_o}, 3'b011);
      fire(0, 0, 1, ~pc, 1, pc, 0, '0);
      chk_eq("R11 dec held", {dec_req_o, saved_pc_o == pc}, 2'b11);
      fire(0, 0, 0, '0, 0, '0, 1, dg);
      chk_eq("R8 resume", {resume_o, exc_integrity_o, status_o}, 4'b1011);
      chk_eq("R8 req drop", busy_o, 0);

      // R4 exit
      fire(0, 1, 0, '0, 0, '0, 0, '0);
      chk_eq("R4 exit", {rf_clear_o, status_o}, 3'b100);
      chk_eq("R4 pc cleared", saved_pc_o, 0);
      // R10 return to old address once released, and to 0
      fire(0, 0, 0, '0, 1, pc, 0, '0);
      chk_eq("R10 ret after exit", {dec_req_o, status_o}, 0);
      fire(0, 0, 0, '0, 1, '0, 0, '0);
      chk_eq("R10 ret zero", {dec_req_o, status_o}, 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule